// File: doc/BRIEF.md
# PCI Configuration Address Encoder

This block turns a configuration request (bus number, device/function byte, register offset) into the two values a host bridge needs to reach PCI configuration space through a 16 MB local-bus aperture. The first value is the byte offset into that aperture. The second is the value for the aperture's translation (map) register. Bus 0 is the segment attached directly to the bridge, so it gets a Type 0 cycle with a one-hot device select line. Any other bus number gets a Type 1 cycle, in which the bus, device and function are encoded as fields.

A 16 MB aperture only reaches address bits 23:0. The select line of a Type 0 device whose select bit would fall at bit 24 or above cannot be carried in the offset. For those slots the encoder sets the matching bit in the map register instead. The map register translates upper address bits, with map bit k standing for PCI address bit k+16. The map register is 16 bits wide, so map bit 15 is the highest one it can set.

The encoder also range-checks its inputs. The ports are wider than a byte, and any value above 255 is flagged as an error. A request strobe produces a registered result with a valid strobe one cycle later. Between requests the registered result holds.

Top module: `cfg_addr_encoder`

## Requirements
- R1: A request with bus 0 yields a Type 0 result: map bits 3:0 equal 4'hA (cycle type 101 in bits 3:1, bit 0 cleared). A request with any other bus yields map bits 3:0 equal 4'hB.
- R2: In a Type 0 result, the function number devfn[2:0] appears at address bits 10:8 and the register offset at address bits 7:0.
- R3: In a Type 0 result with slot (devfn[7:4:3], that is devfn[7:3]) from 0 to 12, address bit slot+11 is the only select bit set in address bits 31:11, and map bits 15:4 are zero.
- R4: In a Type 0 result with slot from 13 to 20, map bit slot-5 is the only bit set in map bits 15:4, and address bits 31:11 are zero.
- R5: In a Type 0 result with slot from 21 to 31, no select bit is set: address bits 31:11 and map bits 15:4 are all zero.
- R6: A Type 1 result has the bus number in address bits 23:16, devfn[7:3] in bits 15:11, devfn[2:0] in bits 10:8, the offset in bits 7:0 and zero in bits 31:24. Its map value is exactly 16'h000B.
- R7: If the bus, devfn or offset input exceeds 255, the result has err_o=1 and both addr_o and map_o equal zero. Otherwise err_o=0.
- R8: valid_o is high in exactly the cycle after each cycle in which req_i is high, including back-to-back requests.
- R9: In a cycle without a request, addr_o, map_o and err_o keep their previous values.
- R10: After reset, valid_o, err_o, addr_o and map_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled each clock |
| bus_i | input | ARG_W | Bus number |
| devfn_i | input | ARG_W | Device/function byte: slot in [7:3], function in [2:0] |
| offset_i | input | ARG_W | Configuration register byte offset |
| valid_o | output | 1 | Result valid, one cycle after req_i |
| err_o | output | 1 | An input was above 255 |
| addr_o | output | 32 | Byte offset into the configuration aperture |
| map_o | output | 16 | Value for the aperture map register |

## Verification
The bench goes after the slot 12/13 and 20/21 boundaries. There, a wrong split constant moves the select line into the wrong register, or sets it twice. A wrong map width lets a truncated bit wrap into a low map bit. It sweeps every slot on bus 0, so an off-by-one in the select position shows up as a neighbouring device being addressed.

It drives bus 0 against bus 1 to catch a Type 0/Type 1 decision taken on the wrong condition. It drives each input just above 255 on its own, which exposes an error check that truncates to a byte and silently aliases onto a legal device. Idle and back-to-back request sequences expose outputs that clear or drift between requests, and a valid strobe that is stretched or dropped.

// File: rtl/cfgenc_pkg.sv
package cfgenc_pkg;
  localparam int ADDR_W     = 32;
  localparam int MAP_W      = 16;
  localparam int FIELD_W    = 8;            // bus, devfn and offset are bytes
  localparam int SLOT_W     = 5;
  localparam int FUNC_W     = 3;
  localparam int SLOTS      = 1 << SLOT_W;
  localparam int FUNC_LSB   = 8;
  localparam int SEL_BASE   = 11;           // address bit of slot 0 select
  localparam int WIN_BITS   = 24;           // 16 MB aperture
  localparam int MAP_SHIFT  = 16;           // map bit k translates address bit k+16
  localparam int SEL_SPLIT  = WIN_BITS - 1 - SEL_BASE;
  localparam int ARG_LIMIT  = (1 << FIELD_W) - 1;
  localparam logic [2:0] CFG_CODE = 3'b101;

  typedef enum logic {CYC_T0 = 1'b0, CYC_T1 = 1'b1} cyc_kind_e;
endpackage

// File: rtl/cfgenc_range_chk.sv
module cfgenc_range_chk #(
  parameter int ARG_W = 10,
  parameter int LIMIT = cfgenc_pkg::ARG_LIMIT
) (
  input  logic [ARG_W-1:0] bus_i,
  input  logic [ARG_W-1:0] devfn_i,
  input  logic [ARG_W-1:0] offset_i,
  output logic             bad_o
);
  localparam logic [ARG_W-1:0] LIM = ARG_W'(LIMIT);

  logic [2:0] over;
  assign over[0] = bus_i    > LIM;
  assign over[1] = devfn_i  > LIM;
  assign over[2] = offset_i > LIM;
  assign bad_o   = |over;
endmodule

// File: rtl/cfgenc_type0.sv
module cfgenc_type0
  import cfgenc_pkg::*;
#(
  parameter int SPLIT  = SEL_SPLIT,
  parameter int BASE   = SEL_BASE,
  parameter int MSHIFT = MAP_SHIFT
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MAP_W-1:0]  map_o
);
  logic [SLOTS-1:0]  slot_hot;
  logic [ADDR_W-1:0] addr_part [SLOTS];
  logic [MAP_W-1:0]  map_part  [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_hot[s] = (slot_i == SLOT_W'(s));
    if (s <= SPLIT && s + BASE < ADDR_W) begin : g_in_addr
      assign addr_part[s] = slot_hot[s] ? (ADDR_W'(1) << (s + BASE)) : '0;
      assign map_part[s]  = '0;
    end else if (s > SPLIT && s + BASE >= MSHIFT && s + BASE - MSHIFT < MAP_W) begin : g_in_map
      assign addr_part[s] = '0;
      assign map_part[s]  = slot_hot[s] ? (MAP_W'(1) << (s + BASE - MSHIFT)) : '0;
    end else begin : g_lost
      // select line beyond map width: no device can be reached
      assign addr_part[s] = '0;
      assign map_part[s]  = '0;
    end
  end

  always_comb begin
    addr_o = '0;
    map_o  = {{(MAP_W-4){1'b0}}, CFG_CODE, 1'b0};
    for (int s = 0; s < SLOTS; s++) begin
      addr_o = addr_o | addr_part[s];
      map_o  = map_o  | map_part[s];
    end
    addr_o[FUNC_LSB +: FUNC_W] = func_i;
  end
endmodule

// File: rtl/cfgenc_type1.sv
module cfgenc_type1
  import cfgenc_pkg::*;
(
  input  logic [FIELD_W-1:0] bus_i,
  input  logic [FIELD_W-1:0] devfn_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [MAP_W-1:0]   map_o
);
  assign addr_o = ADDR_W'({bus_i, devfn_i}) << FIELD_W;
  assign map_o  = {{(MAP_W-4){1'b0}}, CFG_CODE, 1'b1};
endmodule

// File: rtl/cfg_addr_encoder.sv
module cfg_addr_encoder
  import cfgenc_pkg::*;
#(
  parameter int ARG_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ARG_W-1:0]  bus_i,
  input  logic [ARG_W-1:0]  devfn_i,
  input  logic [ARG_W-1:0]  offset_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MAP_W-1:0]  map_o
);
  logic [FIELD_W-1:0] bus_b, devfn_b, off_b;
  logic               bad;
  cyc_kind_e          kind;
  logic [ADDR_W-1:0]  t0_addr, t1_addr, addr_d;
  logic [MAP_W-1:0]   t0_map, t1_map, map_d;

  assign bus_b   = bus_i[FIELD_W-1:0];
  assign devfn_b = devfn_i[FIELD_W-1:0];
  assign off_b   = offset_i[FIELD_W-1:0];

  cfgenc_range_chk #(.ARG_W(ARG_W)) i_chk (
    .bus_i(bus_i), .devfn_i(devfn_i), .offset_i(offset_i), .bad_o(bad)
  );

  cfgenc_type0 i_t0 (
    .slot_i(devfn_b[FIELD_W-1 -: SLOT_W]), .func_i(devfn_b[FUNC_W-1:0]),
    .addr_o(t0_addr), .map_o(t0_map)
  );

  cfgenc_type1 i_t1 (
    .bus_i(bus_b), .devfn_i(devfn_b), .addr_o(t1_addr), .map_o(t1_map)
  );

  assign kind   = (bus_b == '0) ? CYC_T0 : CYC_T1;
  assign addr_d = ((kind == CYC_T0) ? t0_addr : t1_addr) + ADDR_W'(off_b);
  assign map_d  = (kind == CYC_T0) ? t0_map : t1_map;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      addr_o  <= '0;
      map_o   <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        err_o  <= bad;
        addr_o <= bad ? '0 : addr_d;
        map_o  <= bad ? '0 : map_d;
      end
    end
  end

  localparam logic [ARG_W-1:0] LIM = ARG_W'(ARG_LIMIT);

  // R8
  p_valid_after_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_no_stray_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  // R7
  p_err_zeroes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (addr_o == '0 && map_o == '0));
  p_err_raised_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (bus_i > LIM || devfn_i > LIM || offset_i > LIM)) |=> err_o);
  // R9
  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(addr_o) && $stable(map_o) && $stable(err_o)));
  // R3 R4 R5: at most one select line in a Type 0 result
  p_single_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o && !map_o[0]) |-> $onehot0({addr_o[ADDR_W-1:SEL_BASE], map_o[MAP_W-1:4]}));
  // R6
  p_t1_upper_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o && map_o[0]) |-> (addr_o[ADDR_W-1:WIN_BITS] == '0 && map_o == 16'h000B));
  // R1
  p_kind_by_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bus_i == '0 && devfn_i <= LIM && offset_i <= LIM) |=> (map_o[3:0] == 4'hA));
endmodule

// File: tb/test_cfg_addr_encoder.sv
`timescale 1ns/1ps
module test_cfg_addr_encoder;
  localparam int ARG_W = 10;
  localparam int NV    = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [ARG_W-1:0] bus = '0, devfn = '0, offs = '0;
  logic valid, err;
  logic [31:0] addr;
  logic [15:0] map;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cfg_addr_encoder #(.ARG_W(ARG_W)) i_cfg_addr_encoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .bus_i(bus), .devfn_i(devfn),
    .offset_i(offs), .valid_o(valid), .err_o(err), .addr_o(addr), .map_o(map)
  );

  // {bus, devfn, offset, addr, map, err}
  localparam logic [78:0] VEC [NV] = '{
    {10'h000, 10'h000, 10'h000, 32'h0000_0800, 16'h000A, 1'b0},  // R3 slot 0
    {10'h000, 10'h00B, 10'h010, 32'h0000_1310, 16'h000A, 1'b0},  // R2 slot 1 fn 3
    {10'h000, 10'h060, 10'h004, 32'h0080_0004, 16'h000A, 1'b0},  // R3 slot 12
    {10'h000, 10'h068, 10'h000, 32'h0000_0000, 16'h010A, 1'b0},  // R4 slot 13
    {10'h000, 10'h0A7, 10'h0FC, 32'h0000_07FC, 16'h800A, 1'b0},  // R4 slot 20
    {10'h000, 10'h0A8, 10'h008, 32'h0000_0008, 16'h000A, 1'b0},  // R5 slot 21
    {10'h001, 10'h000, 10'h000, 32'h0001_0000, 16'h000B, 1'b0},  // R1 bus 1
    {10'h0FF, 10'h0FF, 10'h0FF, 32'h00FF_FFFF, 16'h000B, 1'b0},  // R6 max legal
    {10'h012, 10'h04D, 10'h040, 32'h0012_4D40, 16'h000B, 1'b0},  // R6
    {10'h100, 10'h000, 10'h000, 32'h0000_0000, 16'h0000, 1'b1},  // R7 bus
    {10'h000, 10'h100, 10'h000, 32'h0000_0000, 16'h0000, 1'b1},  // R7 devfn
    {10'h000, 10'h008, 10'h100, 32'h0000_0000, 16'h0000, 1'b1},  // R7 offset
    {10'h3FF, 10'h3FF, 10'h3FF, 32'h0000_0000, 16'h0000, 1'b1}   // R7 all
  };

  task automatic check(input string tag, input logic v_exp, input logic e_exp,
                       input logic [31:0] a_exp, input logic [15:0] m_exp);
    checks++;
    if (valid !== v_exp || err !== e_exp || addr !== a_exp || map !== m_exp) begin
      fails++;
      $display("FAIL %s: got valid=%b err=%b addr=%h map=%h, expected valid=%b err=%b addr=%h map=%h",
               tag, valid, err, addr, map, v_exp, e_exp, a_exp, m_exp);
    end
  endtask

  task automatic issue(input logic [ARG_W-1:0] b, input logic [ARG_W-1:0] d,
                       input logic [ARG_W-1:0] o);
    @(negedge clk);
    bus = b; devfn = d; offs = o; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ea;
    logic [15:0] em;
    repeat (3) @(negedge clk);
    check("R10 reset", 1'b0, 1'b0, 32'h0, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 1'b0, 1'b0, 32'h0, 16'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][78:69], VEC[i][68:59], VEC[i][58:49]);
      check($sformatf("vector %0d (R1-table)", i), 1'b1, VEC[i][0], VEC[i][48:17], VEC[i][16:1]);
    end

    // R3 R4 R5 R2: every slot on bus 0
    for (int s = 0; s < 32; s++) begin
      ea = 32'((s % 8) << 8) | 32'(s * 4);
      em = 16'h000A;
      if (s <= 12) ea = ea | (32'h1 << (s + 11));
      else if (s <= 20) em = em | (16'h1 << (s - 5));
      issue(10'h000, ARG_W'(s * 8 + (s % 8)), ARG_W'(s * 4));
      check($sformatf("%s slot %0d", (s <= 12) ? "R3" : (s <= 20) ? "R4" : "R5", s),
            1'b1, 1'b0, ea, em);
    end

    // R6: Type 1 sweep
    for (int b = 1; b < 256; b += 37) begin
      issue(ARG_W'(b), ARG_W'(b ^ 8'h5A), 10'h024);
      ea = (32'(b) << 16) | (32'(b ^ 8'h5A) << 8) | 32'h24;
      check($sformatf("R6 bus %0d", b), 1'b1, 1'b0, ea, 16'h000B);
    end

    // R8 R9: back-to-back then idle
    @(negedge clk);
    bus = 10'h000; devfn = 10'h010; offs = 10'h000; req = 1'b1;  // slot 2
    @(negedge clk);
    check("R8 back-to-back first", 1'b1, 1'b0, 32'h0000_2000, 16'h000A);
    bus = 10'h005; devfn = 10'h011; offs = 10'h00C;
    @(negedge clk);
    check("R8 back-to-back second", 1'b1, 1'b0, 32'h0005_110C, 16'h000B);
    req = 1'b0;
    bus = 10'h3FF; devfn = 10'h3FF; offs = 10'h3FF;   // changed while idle
    @(negedge clk);
    check("R9 idle hold", 1'b0, 1'b0, 32'h0005_110C, 16'h000B);
    repeat (3) @(negedge clk);
    check("R9 idle hold later", 1'b0, 1'b0, 32'h0005_110C, 16'h000B);

    // R7 then clean request clears error
    issue(10'h000, 10'h000, 10'h1FF);
    check("R7 offset over", 1'b1, 1'b1, 32'h0, 16'h0);
    @(negedge clk);
    check("R9 error held", 1'b0, 1'b1, 32'h0, 16'h0);
    issue(10'h000, 10'h000, 10'h0FF);
    check("R7 legal clears err", 1'b1, 1'b0, 32'h0000_08FF, 16'h000A);

    // R10: reset mid-run
    rst_n = 1'b0;
    #1;
    check("R10 async reset", 1'b0, 1'b0, 32'h0, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule